// File: doc/BRIEF.md
# DMA descriptor fetch sequencer

This block fills a DMA channel's working registers from a descriptor stored as consecutive 16-bit words in memory. Software first places a pointer in the next-descriptor or current-descriptor register, then writes the channel configuration word. That configuration write starts the sequencer. The flow field of the word selects what happens next: stop, descriptor array, small list or large list. The element-count field sets how many descriptor words are read before the payload transfer may begin.

The sequencer reads one word at a time over a simple request/valid port. The read address is always the current-descriptor pointer, which advances after each word. In list modes the pointer is first loaded from the next-descriptor pointer. Next-pointer elements refresh that register while the fetch carries on from the current pointer. A configuration element read from memory becomes the channel configuration when the fetch ends. At that point a one-cycle start pulse tells the transfer engine that it may run.

Top module: `dfs_fetch_seq`

## Requirements
- R1: After reset, every pointer and working register and the configuration output read 0, and `busy`, `mem_req` and `xfer_start` are low.
- R2: A configuration write while idle always loads the written word into `cfg_out`. The word has enable at bit 0, element count at bits 11:8 and flow at bits 14:12. A fetch starts only when enable is 1, flow is 4, 6 or 7, and the clamped count is non-zero. When enable is 0, no fetch and no start pulse follow.
- R3: For flow 6 (small list) and flow 7 (large list), the next-descriptor pointer is copied into the current-descriptor pointer before the first read. For flow 4 (array), reads begin at the existing current-descriptor pointer.
- R4: Each read is issued at the current-descriptor pointer, and the pointer grows by 2 after each accepted word. Only one read is outstanding at a time, and `mem_addr` holds steady until `mem_valid` is seen.
- R5: Elements are fetched in this order: next-pointer low, next-pointer high, start-address low, start-address high, configuration, X count, X modify, Y count, Y modify. Flow 7 begins with next-pointer low. Flow 6 omits the next-pointer high element. Flow 4 begins at start-address low.
- R6: A next-pointer element replaces only its own 16-bit half of `next_ptr`, and the running fetch keeps reading from the current pointer.
- R7: At completion, `curr_ptr` equals its start value plus 2 times the number of elements fetched.
- R8: The element count is clamped to 7 (flow 4), 8 (flow 6) or 9 (flow 7). An enabled write whose clamped count is 0, or whose flow is any other value, gives the start pulse with no read and no pointer change.
- R9: Working registers whose elements were not fetched keep their previous values.
- R10: During a fetch, `cfg_out` keeps the software-written word. At completion, a fetched configuration element replaces it. If no configuration element was fetched, the software word stays.
- R11: Configuration and pointer writes that arrive while `busy` is high are ignored.
- R12: `xfer_start` is a one-cycle pulse. It comes in the cycle after the last element is accepted, and only if bit 0 of the resulting configuration is 1. For an immediate start, it comes in the cycle after the configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Software configuration write strobe |
| cfg_wdata | input | 16 | Configuration word written by software |
| ptr_wr | input | 1 | Software pointer write strobe |
| ptr_sel | input | 1 | Pointer to write: 0 next-descriptor, 1 current-descriptor |
| ptr_wdata | input | 32 | Pointer value written by software |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Byte address of the requested 16-bit word |
| mem_rdata | input | 16 | Read data, taken when `mem_valid` is high |
| mem_valid | input | 1 | Read data valid |
| busy | output | 1 | Descriptor fetch in progress |
| xfer_start | output | 1 | One-cycle start pulse for the transfer engine |
| cfg_out | output | 16 | Active channel configuration |
| next_ptr | output | 32 | Next-descriptor pointer |
| curr_ptr | output | 32 | Current-descriptor pointer |
| start_addr | output | 32 | Payload start address |
| x_count | output | 16 | Inner-loop count |
| x_modify | output | 16 | Inner-loop stride |
| y_count | output | 16 | Outer-loop count |
| y_modify | output | 16 | Outer-loop stride |

## Verification
The bench builds the block with its default 2-byte pointer step and a 128-word descriptor memory indexed by address bits 7:1. This lets a pointer with a non-zero upper half still reach real descriptor words, so a small list can show that only the low half of `next_ptr` changes. Memory latencies of 0, 1, 2 and 3 cycles exercise the held request and back-to-back accepts. A long array fetch with a latency of 2 leaves enough cycles to inject writes while the sequencer is busy.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    localparam int PTR_W  = 32;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 4;

    // configuration word fields
    localparam int CFG_EN_BIT  = 0;
    localparam int CNT_LSB     = 8;
    localparam int FLOW_LSB    = 12;

    localparam logic [2:0] FLOW_ARRAY = 3'd4;
    localparam logic [2:0] FLOW_SMALL = 3'd6;
    localparam logic [2:0] FLOW_LARGE = 3'd7;

    typedef enum logic [1:0] {
        MODE_NONE,
        MODE_ARRAY,
        MODE_SMALL,
        MODE_LARGE
    } fmode_e;

    typedef enum logic [3:0] {
        EL_NPL,
        EL_NPH,
        EL_SAL,
        EL_SAH,
        EL_CFG,
        EL_XCNT,
        EL_XMOD,
        EL_YCNT,
        EL_YMOD
    } elem_e;

    typedef struct packed {
        logic [PTR_W-1:0]  next_ptr;
        logic [PTR_W-1:0]  start_addr;
        logic [WORD_W-1:0] x_cnt;
        logic [WORD_W-1:0] x_mod;
        logic [WORD_W-1:0] y_cnt;
        logic [WORD_W-1:0] y_mod;
    } wregs_t;

    function automatic fmode_e flow_to_mode(input logic [2:0] flow);
        case (flow)
            FLOW_ARRAY: return MODE_ARRAY;
            FLOW_SMALL: return MODE_SMALL;
            FLOW_LARGE: return MODE_LARGE;
            default:    return MODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dfs_elem_map.sv
module dfs_elem_map
    import dfs_pkg::*;
(
    input  fmode_e           mode,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] nsize,
    output elem_e            kind,
    output logic [IDX_W-1:0] count
);
    localparam logic [IDX_W-1:0] MAX_ARRAY = IDX_W'(7);
    localparam logic [IDX_W-1:0] MAX_SMALL = IDX_W'(8);
    localparam logic [IDX_W-1:0] MAX_LARGE = IDX_W'(9);

    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] lim;

    always_comb begin
        case (mode)
            MODE_ARRAY: begin pos = idx + IDX_W'(2); lim = MAX_ARRAY; end
            MODE_SMALL: begin
                pos = (idx == '0) ? '0 : idx + IDX_W'(1);
                lim = MAX_SMALL;
            end
            MODE_LARGE: begin pos = idx; lim = MAX_LARGE; end
            default:    begin pos = '0;  lim = '0;        end
        endcase
        kind  = elem_e'(pos);
        count = (nsize > lim) ? lim : nsize;
    end
endmodule

// File: rtl/dfs_reg_load.sv
module dfs_reg_load
    import dfs_pkg::*;
(
    input  wregs_t            cur,
    input  elem_e             kind,
    input  logic [WORD_W-1:0] data,
    input  logic              load,
    output wregs_t            nxt
);
    always_comb begin
        nxt = cur;
        if (load) begin
            case (kind)
                EL_NPL:  nxt.next_ptr[WORD_W-1:0]       = data;
                EL_NPH:  nxt.next_ptr[PTR_W-1:WORD_W]   = data;
                EL_SAL:  nxt.start_addr[WORD_W-1:0]     = data;
                EL_SAH:  nxt.start_addr[PTR_W-1:WORD_W] = data;
                EL_XCNT: nxt.x_cnt = data;
                EL_XMOD: nxt.x_mod = data;
                EL_YCNT: nxt.y_cnt = data;
                EL_YMOD: nxt.y_mod = data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dfs_fetch_seq.sv
module dfs_fetch_seq
    import dfs_pkg::*;
#(
    parameter int STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              ptr_wr,
    input  logic              ptr_sel,
    input  logic [PTR_W-1:0]  ptr_wdata,
    output logic              mem_req,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_valid,
    output logic              busy,
    output logic              xfer_start,
    output logic [WORD_W-1:0] cfg_out,
    output logic [PTR_W-1:0]  next_ptr,
    output logic [PTR_W-1:0]  curr_ptr,
    output logic [PTR_W-1:0]  start_addr,
    output logic [WORD_W-1:0] x_count,
    output logic [WORD_W-1:0] x_modify,
    output logic [WORD_W-1:0] y_count,
    output logic [WORD_W-1:0] y_modify
);
    localparam logic [PTR_W-1:0] PTR_STEP = PTR_W'(STEP);

    typedef enum logic {S_IDLE, S_FETCH} st_e;

    typedef struct packed {
        st_e               st;
        logic [PTR_W-1:0]  curr;
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] cfg_sh;
        logic              cfg_got;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  cnt;
        fmode_e            mode;
        wregs_t            w;
        logic              xfer;
    } ctl_t;

    ctl_t s_q, s_d;

    fmode_e           wr_mode;
    elem_e            wr_kind_unused;
    logic [IDX_W-1:0] wr_count;
    elem_e            cur_kind;
    logic [IDX_W-1:0] cur_count_unused;
    wregs_t           w_loaded;
    logic [WORD_W-1:0] fin_cfg;

    assign wr_mode = flow_to_mode(cfg_wdata[FLOW_LSB +: 3]);

    dfs_elem_map u_map_wr (
        .mode  (wr_mode),
        .idx   ('0),
        .nsize (cfg_wdata[CNT_LSB +: IDX_W]),
        .kind  (wr_kind_unused),
        .count (wr_count)
    );

    dfs_elem_map u_map_cur (
        .mode  (s_q.mode),
        .idx   (s_q.idx),
        .nsize (s_q.cnt),
        .kind  (cur_kind),
        .count (cur_count_unused)
    );

    dfs_reg_load u_load (
        .cur  (s_q.w),
        .kind (cur_kind),
        .data (mem_rdata),
        .load (mem_valid),
        .nxt  (w_loaded)
    );

    always_comb begin
        s_d      = s_q;
        s_d.xfer = 1'b0;
        fin_cfg  = s_q.cfg_got ? s_q.cfg_sh : s_q.cfg;
        case (s_q.st)
            S_IDLE: begin
                if (ptr_wr) begin
                    if (ptr_sel) s_d.curr       = ptr_wdata;
                    else         s_d.w.next_ptr = ptr_wdata;
                end
                if (cfg_wr) begin
                    s_d.cfg     = cfg_wdata;
                    s_d.cfg_got = 1'b0;
                    if (cfg_wdata[CFG_EN_BIT]) begin
                        if (wr_count != '0) begin
                            s_d.st   = S_FETCH;
                            s_d.idx  = '0;
                            s_d.cnt  = wr_count;
                            s_d.mode = wr_mode;
                            if (wr_mode == MODE_SMALL || wr_mode == MODE_LARGE)
                                s_d.curr = s_d.w.next_ptr;
                        end else begin
                            s_d.xfer = 1'b1;
                        end
                    end
                end
            end
            S_FETCH: begin
                if (mem_valid) begin
                    s_d.w    = w_loaded;
                    s_d.curr = s_q.curr + PTR_STEP;
                    s_d.idx  = s_q.idx + IDX_W'(1);
                    if (cur_kind == EL_CFG) begin
                        s_d.cfg_sh  = mem_rdata;
                        s_d.cfg_got = 1'b1;
                        fin_cfg     = mem_rdata;
                    end
                    if (s_q.idx == s_q.cnt - IDX_W'(1)) begin
                        s_d.st   = S_IDLE;
                        s_d.cfg  = fin_cfg;
                        s_d.xfer = fin_cfg[CFG_EN_BIT];
                    end
                end
            end
            default: s_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.st == S_FETCH);
    assign mem_req    = busy;
    assign mem_addr   = s_q.curr;
    assign xfer_start = s_q.xfer;
    assign cfg_out    = s_q.cfg;
    assign next_ptr   = s_q.w.next_ptr;
    assign curr_ptr   = s_q.curr;
    assign start_addr = s_q.w.start_addr;
    assign x_count    = s_q.w.x_cnt;
    assign x_modify   = s_q.w.x_mod;
    assign y_count    = s_q.w.y_cnt;
    assign y_modify   = s_q.w.y_mod;

endmodule

// File: rtl/dfs_fetch_seq_chk.sv
module dfs_fetch_seq_chk #(
    parameter int STEP = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_valid,
    input logic [31:0] mem_addr,
    input logic [31:0] curr_ptr,
    input logic [31:0] next_ptr,
    input logic [15:0] cfg_out,
    input logic        busy,
    input logic        ptr_wr,
    input logic        xfer_start
);
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && mem_addr == $past(mem_addr)));

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid) |=> (curr_ptr == $past(curr_ptr) + 32'(STEP)));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_valid) |=> $stable(cfg_out));

    a_r11_next_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ptr_wr && !mem_valid) |=> $stable(next_ptr));

    a_r12_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |-> !busy);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

bind dfs_fetch_seq dfs_fetch_seq_chk #(.STEP(STEP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .curr_ptr   (curr_ptr),
    .next_ptr   (next_ptr),
    .cfg_out    (cfg_out),
    .busy       (busy),
    .ptr_wr     (ptr_wr),
    .xfer_start (xfer_start)
);

// File: tb/dfs_fetch_seq_bench.sv
module dfs_fetch_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ptr_wr = 1'b0;
    logic        ptr_sel = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        mem_valid = 1'b0;
    logic        busy, xfer_start;
    logic [15:0] cfg_out, x_count, x_modify, y_count, y_modify;
    logic [31:0] next_ptr, curr_ptr, start_addr;

    always #5 clk = ~clk;

    dfs_fetch_seq u_dfs_fetch_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ptr_wr(ptr_wr), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_valid(mem_valid), .busy(busy), .xfer_start(xfer_start),
        .cfg_out(cfg_out), .next_ptr(next_ptr), .curr_ptr(curr_ptr),
        .start_addr(start_addr), .x_count(x_count), .x_modify(x_modify),
        .y_count(y_count), .y_modify(y_modify)
    );

    typedef struct {
        logic [31:0] nxt, cur, sa;
        logic [15:0] cfg, xc, xm, yc, ym;
        logic        xfer;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    logic [15:0] mem [0:127];
    int n_chk = 0, n_fail = 0, done_cnt = 0, lat = 0, wait_cnt = 0;
    bit finished = 0;
    logic prev_busy = 1'b0;

    logic [31:0] m_next = '0, m_curr = '0, m_start = '0;
    logic [15:0] m_cfg = '0, m_xc = '0, m_xm = '0, m_yc = '0, m_ym = '0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: answers after lat idle cycles, checks the read address order
    always @(negedge clk) begin
        if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_valid = 1'b1;
                mem_rdata = mem[mem_addr[7:1]];
                wait_cnt  = 0;
                if (addr_q.size() == 0) check("R4", "unexpected read", mem_addr, 32'hFFFF_FFFF);
                else check("R4/R5", "read address", mem_addr, addr_q.pop_front());
            end else begin
                mem_valid = 1'b0;
                wait_cnt++;
            end
        end else begin
            mem_valid = 1'b0;
            wait_cnt  = 0;
        end
    end

    // monitor: compares each completion against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (xfer_start || (prev_busy && !busy))) begin
            if (exp_q.size() == 0) begin
                check("R12", "unexpected completion", 32'(xfer_start), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "next_ptr (R6)", next_ptr, e.nxt);
                check(e.tag, "curr_ptr (R7)", curr_ptr, e.cur);
                check(e.tag, "start_addr", start_addr, e.sa);
                check(e.tag, "cfg_out (R10)", 32'(cfg_out), 32'(e.cfg));
                check(e.tag, "x_count (R9)", 32'(x_count), 32'(e.xc));
                check(e.tag, "x_modify", 32'(x_modify), 32'(e.xm));
                check(e.tag, "y_count", 32'(y_count), 32'(e.yc));
                check(e.tag, "y_modify", 32'(y_modify), 32'(e.ym));
                check(e.tag, "xfer_start (R12)", 32'(xfer_start), 32'(e.xfer));
            end
            done_cnt++;
        end
        prev_busy = busy;
    end

    task automatic set_ptr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        ptr_wr = 1'b1; ptr_sel = sel; ptr_wdata = v;
        @(negedge clk);
        ptr_wr = 1'b0;
        if (sel) m_curr = v; else m_next = v;
    endtask

    // driver: models the requirements, pushes expectations, then writes the config word
    task automatic run_cfg(input logic [15:0] c, input int lat_i, input bit inject,
                           input string tag);
        exp_t e;
        logic [2:0] fl;
        int maxn, n, snap, k;
        bit known, got, fetching, pushed;
        logic [15:0] fc, d;
        fl = c[14:12];
        known = 1'b1;
        case (fl)
            3'd4: maxn = 7;
            3'd6: maxn = 8;
            3'd7: maxn = 9;
            default: begin maxn = 0; known = 1'b0; end
        endcase
        n = (int'(c[11:8]) > maxn) ? maxn : int'(c[11:8]);
        fetching = c[0] && known && (n > 0);
        pushed = c[0];
        got = 1'b0; fc = '0;
        if (fetching) begin
            if (fl != 3'd4) m_curr = m_next;
            for (int i = 0; i < n; i++) begin
                if (fl == 3'd7)      k = i;
                else if (fl == 3'd6) k = (i == 0) ? 0 : i + 1;
                else                 k = i + 2;
                addr_q.push_back(m_curr);
                d = mem[m_curr[7:1]];
                case (k)
                    0: m_next[15:0]   = d;
                    1: m_next[31:16]  = d;
                    2: m_start[15:0]  = d;
                    3: m_start[31:16] = d;
                    4: begin fc = d; got = 1'b1; end
                    5: m_xc = d;
                    6: m_xm = d;
                    7: m_yc = d;
                    default: m_ym = d;
                endcase
                m_curr = m_curr + 32'd2;
            end
        end
        m_cfg = got ? fc : c;
        if (pushed) begin
            e.nxt = m_next; e.cur = m_curr; e.sa = m_start; e.cfg = m_cfg;
            e.xc = m_xc; e.xm = m_xm; e.yc = m_yc; e.ym = m_ym;
            e.xfer = m_cfg[0]; e.tag = tag;
            exp_q.push_back(e);
        end
        lat = lat_i;
        snap = done_cnt;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = c;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (fetching) begin
            check("R2", {tag, " busy after start"}, 32'(busy), 32'd1);
            check("R10", {tag, " cfg during fetch"}, 32'(cfg_out), 32'(c));
            if (inject) begin
                ptr_wr = 1'b1; ptr_sel = 1'b0; ptr_wdata = 32'hDEAD_BEEF;
                cfg_wr = 1'b1; cfg_wdata = 16'h0000;
                @(negedge clk);
                ptr_wr = 1'b0; cfg_wr = 1'b0;
            end
        end
        if (pushed) begin
            for (int t = 0; t < 400 && done_cnt == snap; t++) @(negedge clk);
            check("R12", {tag, " completion seen"}, 32'(done_cnt - snap), 32'd1);
        end else begin
            repeat (6) @(negedge clk);
            check("R2", {tag, " no fetch when disabled"}, 32'(busy), 32'd0);
            check("R2", {tag, " cfg loaded"}, 32'(cfg_out), 32'(c));
        end
        check("R5", {tag, " all reads issued"}, 32'(addr_q.size()), 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic put_desc(input int widx, input logic [15:0] w0, w1, w2, w3, w4,
                            w5, w6, w7, w8);
        mem[widx]   = w0; mem[widx+1] = w1; mem[widx+2] = w2;
        mem[widx+3] = w3; mem[widx+4] = w4; mem[widx+5] = w5;
        mem[widx+6] = w6; mem[widx+7] = w7; mem[widx+8] = w8;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 16'h1000 + 16'(i) * 16'h0101;
        // large list at byte 0x10
        put_desc(8, 16'h0040, 16'h0001, 16'h1234, 16'h5678, 16'h000B,
                 16'h0010, 16'h0002, 16'h0004, 16'hFFF0);
        // small list at byte 0x40 (8 words; ninth slot unused)
        put_desc(32, 16'h0060, 16'hAAAA, 16'hBBBB, 16'h0031, 16'h0020,
                 16'h0004, 16'h0008, 16'h0040, 16'h9999);
        // array descriptor at byte 0x80, configuration element disabled
        put_desc(64, 16'hC0DE, 16'h00C0, 16'h0000, 16'h7777, 16'h6666,
                 16'h5555, 16'h4444, 16'h3333, 16'h2222);

        repeat (3) @(negedge clk);
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "mem_req", 32'(mem_req), 32'd0);
        check("R1", "xfer_start", 32'(xfer_start), 32'd0);
        check("R1", "cfg_out", 32'(cfg_out), 32'd0);
        check("R1", "curr_ptr", curr_ptr, 32'd0);
        check("R1", "next_ptr", next_ptr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        set_ptr(1'b0, 32'h0000_0010);
        run_cfg(16'h7971, 1, 1'b0, "R3 large list");
        run_cfg(16'h6801, 0, 1'b0, "R6 small list");
        set_ptr(1'b1, 32'h0000_0080);
        run_cfg(16'h4301, 0, 1'b0, "R9 array partial");
        run_cfg(16'h4F01, 2, 1'b1, "R11 array clamp");
        run_cfg(16'h7001, 0, 1'b0, "R8 zero count");
        run_cfg(16'h0501, 0, 1'b0, "R8 stop flow");
        run_cfg(16'h2501, 0, 1'b0, "R8 other flow");
        run_cfg(16'h7900, 0, 1'b0, "R2 disabled");
        set_ptr(1'b0, 32'h0000_0040);
        run_cfg(16'h6F01, 3, 1'b0, "R7 small clamp");
        set_ptr(1'b1, 32'h0000_0000);
        run_cfg(16'h4201, 1, 1'b0, "R10 array no cfg");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule